// File: doc/BRIEF.md
# SPI Serial EEPROM Command Sequencer

This block is the slave-side front end of a small serial non-volatile memory model. A bus master selects it with an active-low chip select, clocks in an 8-bit command and, for memory commands, a 24-bit address. The block then either streams stored bytes back with an auto-incrementing pointer, or gathers up to a page of write data in a staging buffer. SCK, CSb and SI are oversampled in the system clock domain through two-flop synchronizers, so the serial clock must run several times slower than the system clock. Both serial clock polarities are accepted: idle-low with capture on the rising edge, and idle-high with capture on the rising edge.

When the select is released straight after a complete write byte, the block raises a one-cycle request towards a separate status and protection block. That block answers in the same cycle with a grant when the write is enabled and the page is not protected. A granted request commits the staged bytes and starts a self-timed busy window of `WRITE_CYCLES` system clocks. Write-enable and write-disable commands are passed on as one-cycle strobes. A status write is forwarded as a request of its own kind. The block returns the status byte supplied by the protection block, and it returns a fixed identification byte.

The serial side has no back-pressure: the master owns the clock. The only handshake is request/grant. `req_o` is high for exactly one cycle, `grant_i` is sampled in that same cycle, and a request without a grant is dropped without a retry.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset `so_oe_o`, `busy_o`, `req_o` and `cmd_stb_o` are low, and every array byte reads back as FFh.
- R2: SI is captured on rising SCK edges, most significant bit first. SO changes only after a falling SCK edge. Both an idle-low and an idle-high SCK are supported. `so_oe_o` is high only while the block is returning data with CSb low.
- R3: Command 03h takes three address bytes, and only the low `ADDR_W` bits are used. Data then streams out byte after byte with the address rising by one, and it wraps from the last array location to 0.
- R4: Command 02h takes three address bytes and then data bytes. Only the low 8 address bits advance, so bytes past the page end wrap to the start of the same page and overwrite earlier bytes. Only the byte positions actually received are changed in the array.
- R5: When CSb rises while command 02h is active, with at least one whole data byte received and no partial byte pending, `req_o` pulses for one cycle with `req_kind_o`=0 and `req_page_o` = address bits `ADDR_W-1:8`. A rise in the middle of a byte raises no request.
- R6: A request that sees `grant_i` high in its cycle commits its data and holds `busy_o` high for exactly `WRITE_CYCLES` cycles starting at the next cycle. Without a grant, nothing changes and `busy_o` stays low.
- R7: While `busy_o` is high, every command except 05h is refused: no SO output, no strobe and no request until CSb falls again.
- R8: Command 05h returns `status_i` repeatedly, one byte after another, including while busy.
- R9: Commands 06h and 04h pulse `cmd_stb_o` for one cycle with `cmd_code_o` equal to the command byte.
- R10: Command 01h takes one data byte. A CSb rise after that byte pulses `req_o` with `req_kind_o`=1 and `req_data_o` equal to the byte.
- R11: Command ABh followed by three ignored bytes returns 11h repeatedly for as long as SCK runs.
- R12: An unknown command byte makes the block ignore all input and keep `so_oe_o` low until the next CSb fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb_i | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the SO tri-state driver |
| busy_o | output | 1 | Self-timed write cycle in progress |
| cmd_stb_o | output | 1 | One-cycle strobe for enable/disable commands |
| cmd_code_o | output | 8 | Command byte that goes with `cmd_stb_o` |
| req_o | output | 1 | One-cycle write request to the protection block |
| req_kind_o | output | 1 | 0 = page write, 1 = status write |
| req_page_o | output | ADDR_W-8 | Target page of a page write |
| req_data_o | output | 8 | Status byte of a status write |
| grant_i | input | 1 | Same-cycle grant for `req_o` |
| status_i | input | 8 | Status byte returned by command 05h |

## Verification
A bad bit or byte counter shows up at SO within one byte as shifted or misaligned data. It also shows up as a request raised on a partial byte, or one missing on a whole byte. A wrong page index or write mask is invisible until a later read of the touched page, so every write is followed by a read of the bytes around it and across the page edge. A wrong busy count or a busy flag raised without a grant is seen in the first cycle where it departs from the model, because `busy_o` is compared on every clock. A refusal or lock state that fails to hold shows up as SO enabled during the very next byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] CMD_WEN   = 8'h06;
  localparam logic [7:0] CMD_WDIS  = 8'h04;
  localparam logic [7:0] CMD_STRD  = 8'h05;
  localparam logic [7:0] CMD_STWR  = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_IDENT = 8'hAB;
  localparam logic [7:0] ID_BYTE   = 8'h11;

  typedef enum logic [3:0] {
    S_IDLE,    // deselected
    S_CMD,     // collecting command byte
    S_ADR,     // collecting address bytes
    S_RDOUT,   // streaming array data
    S_PGIN,    // collecting page data
    S_STOUT,   // streaming status byte
    S_IDPAD,   // skipping identification padding
    S_IDOUT,   // streaming identification byte
    S_STIN,    // collecting status-write byte
    S_DONE,    // command complete, ignore rest
    S_LOCK     // refused or unknown command
  } seq_state_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int          W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q_o  <= RST;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     we_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [7:0]               data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG    = 1 << PAGE_W;

  logic [7:0]    mem  [DEPTH];
  logic [7:0]    pbuf [PG];
  logic [PG-1:0] mask;

  // staging buffer data, gated by mask so no reset is needed
  always_ff @(posedge clk) begin
    if (we_i) pbuf[idx_i] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (clr_i) begin
      mask <= '0;
    end else if (we_i) begin
      mask[idx_i] <= 1'b1;
    end
  end

  // array starts erased; commit copies only the staged positions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PG; i++) begin
        if (mask[i]) mem[{page_i, PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start_i)      left <= CW'(CYCLES);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy_o = (left != '0);
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import eep_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 8,
  parameter int WRITE_CYCLES = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csb_i,
  input  logic                     sck_i,
  input  logic                     si_i,
  output logic                     so_o,
  output logic                     so_oe_o,
  output logic                     busy_o,
  output logic                     cmd_stb_o,
  output logic [7:0]               cmd_code_o,
  output logic                     req_o,
  output logic                     req_kind_o,
  output logic [ADDR_W-PAGE_W-1:0] req_page_o,
  output logic [7:0]               req_data_o,
  input  logic                     grant_i,
  input  logic [7:0]               status_i
);
  localparam int PG_W = ADDR_W - PAGE_W;

  // synchronised pins: {si, sck, csb}
  logic [2:0] pins_s;
  logic cs_s, sck_s, si_s, cs_p, sck_p;

  eep_sync #(.W(3), .RST(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({si_i, sck_i, csb_i}), .q_o(pins_s)
  );
  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[2];

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_p & ~cs_s;
  assign cs_rise  = ~cs_p & cs_s;
  assign sck_rise = ~sck_p & sck_s & ~cs_s;
  assign sck_fall = sck_p & ~sck_s & ~cs_s;

  seq_state_t        st;
  logic [2:0]        bcnt, ocnt;
  logic [6:0]        shin;
  logic [1:0]        acnt;
  logic [ADDR_W-1:0] addr_sh, rd_ptr;
  logic [7:0]        obuf, rx_byte, rd_data;
  logic              so_r, ld_pend, is_wr, got_byte;
  logic [PAGE_W-1:0] wr_idx;
  logic [PG_W-1:0]   wr_page;
  logic [7:0]        stw_byte;
  logic              req_r, req_kind_r, cmd_stb_r;
  logic [PG_W-1:0]   req_page_r;
  logic [7:0]        req_data_r, cmd_code_r;
  logic              active, out_st, byte_done;
  logic [ADDR_W-1:0] adr_full;

  assign rx_byte  = {shin, si_s};
  assign active   = (st != S_IDLE) && (st != S_DONE) && (st != S_LOCK);
  assign out_st   = (st == S_RDOUT) || (st == S_STOUT) || (st == S_IDOUT);
  assign byte_done = sck_rise && active && (bcnt == 3'd7);
  assign adr_full = {addr_sh[ADDR_W-9:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 1'b1;       sck_p <= 1'b0;
      st <= S_IDLE;       bcnt <= '0;        ocnt <= '0;
      shin <= '0;         acnt <= '0;        addr_sh <= '0;
      rd_ptr <= '0;       obuf <= '0;        so_r <= 1'b0;
      ld_pend <= 1'b0;    is_wr <= 1'b0;     got_byte <= 1'b0;
      wr_idx <= '0;       wr_page <= '0;     stw_byte <= '0;
      req_r <= 1'b0;      req_kind_r <= 1'b0;
      req_page_r <= '0;   req_data_r <= '0;
      cmd_stb_r <= 1'b0;  cmd_code_r <= '0;
    end else begin
      cs_p      <= cs_s;
      sck_p     <= sck_s;
      req_r     <= 1'b0;
      cmd_stb_r <= 1'b0;

      // fetch the next outgoing byte from the source the state selects
      if (ld_pend) begin
        ld_pend <= 1'b0;
        ocnt    <= '0;
        case (st)
          S_RDOUT: begin obuf <= rd_data; rd_ptr <= rd_ptr + 1'b1; end
          S_STOUT: obuf <= status_i;
          default: obuf <= ID_BYTE;
        endcase
      end

      if (cs_rise) begin
        if (st == S_PGIN && bcnt == 3'd0 && got_byte) begin
          req_r      <= 1'b1;
          req_kind_r <= 1'b0;
          req_page_r <= wr_page;
          req_data_r <= '0;
        end else if (st == S_STIN && bcnt == 3'd0 && got_byte) begin
          req_r      <= 1'b1;
          req_kind_r <= 1'b1;
          req_page_r <= '0;
          req_data_r <= stw_byte;
        end
        st      <= S_IDLE;
        ld_pend <= 1'b0;
      end else if (cs_fall) begin
        st       <= S_CMD;
        bcnt     <= '0;
        acnt     <= '0;
        got_byte <= 1'b0;
      end else if (!cs_s) begin
        if (sck_rise && active) begin
          shin <= {shin[5:0], si_s};
          bcnt <= bcnt + 1'b1;
        end

        if (byte_done) begin
          case (st)
            S_CMD: begin
              if (busy_o && rx_byte != CMD_STRD) begin
                st <= S_LOCK;
              end else begin
                case (rx_byte)
                  CMD_WEN, CMD_WDIS: begin
                    cmd_stb_r  <= 1'b1;
                    cmd_code_r <= rx_byte;
                    st         <= S_DONE;
                  end
                  CMD_STRD:  begin st <= S_STOUT; ld_pend <= 1'b1; end
                  CMD_STWR:  st <= S_STIN;
                  CMD_READ:  begin st <= S_ADR; is_wr <= 1'b0; end
                  CMD_PROG:  begin st <= S_ADR; is_wr <= 1'b1; end
                  CMD_IDENT: st <= S_IDPAD;
                  default:   st <= S_LOCK;
                endcase
              end
            end
            S_ADR: begin
              addr_sh <= adr_full;
              acnt    <= acnt + 1'b1;
              if (acnt == 2'd2) begin
                if (is_wr) begin
                  wr_idx  <= adr_full[PAGE_W-1:0];
                  wr_page <= adr_full[ADDR_W-1:PAGE_W];
                  st      <= S_PGIN;
                end else begin
                  rd_ptr  <= adr_full;
                  ld_pend <= 1'b1;
                  st      <= S_RDOUT;
                end
              end
            end
            S_PGIN: begin
              got_byte <= 1'b1;
              wr_idx   <= wr_idx + 1'b1;
            end
            S_STIN: begin
              if (!got_byte) begin
                stw_byte <= rx_byte;
                got_byte <= 1'b1;
              end
            end
            S_IDPAD: begin
              acnt <= acnt + 1'b1;
              if (acnt == 2'd2) begin
                st      <= S_IDOUT;
                ld_pend <= 1'b1;
              end
            end
            default: ;
          endcase
        end

        if (sck_fall && out_st && !ld_pend) begin
          so_r <= obuf[7];
          obuf <= {obuf[6:0], 1'b0};
          ocnt <= ocnt + 1'b1;
          if (ocnt == 3'd7) ld_pend <= 1'b1;
        end
      end
    end
  end

  logic commit, start;
  assign commit = req_r & grant_i & ~req_kind_r;
  assign start  = req_r & grant_i;

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_i(cs_fall),
    .we_i(byte_done && st == S_PGIN),
    .idx_i(wr_idx), .data_i(rx_byte),
    .commit_i(commit), .page_i(req_page_r),
    .rd_addr_i(rd_ptr), .rd_data_o(rd_data)
  );

  eep_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_o)
  );

  assign so_o       = so_r;
  assign so_oe_o    = ~cs_s & out_st;
  assign req_o      = req_r;
  assign req_kind_o = req_kind_r;
  assign req_page_o = req_page_r;
  assign req_data_o = req_data_r;
  assign cmd_stb_o  = cmd_stb_r;
  assign cmd_code_o = cmd_code_r;
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csb_i,
  input logic       so_oe_o,
  input logic       busy_o,
  input logic       req_o,
  input logic       grant_i,
  input logic       cmd_stb_o,
  input logic [7:0] cmd_code_o
);
  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  assert_busy_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && grant_i) |=> busy_o);

  assert_busy_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_o && grant_i));

  assert_refuse_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!req_o && !cmd_stb_o));

  assert_cmd_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> (cmd_code_o == 8'h06 || cmd_code_o == 8'h04));

  assert_oe_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_i && $past(csb_i) && $past(csb_i, 2) && $past(csb_i, 3)) |-> !so_oe_o);
endmodule

bind spi_eeprom_seq eep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csb_i(csb_i), .so_oe_o(so_oe_o),
  .busy_o(busy_o), .req_o(req_o), .grant_i(grant_i),
  .cmd_stb_o(cmd_stb_o), .cmd_code_o(cmd_code_o)
);

// File: tb/sim_spi_eeprom_seq.sv
module sim_spi_eeprom_seq;
  localparam int AW = 10;
  localparam int WC = 1000;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csb = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, busy, cmd_stb, req, req_kind, grant;
  logic [7:0] cmd_code, req_data;
  logic [7:0] status_v = 8'h8C;
  logic [AW-9:0] req_page;
  logic grant_en = 1'b1;
  bit   mode3 = 1'b0;

  always #5 clk = ~clk;
  assign grant = req & grant_en;

  spi_eeprom_seq #(.ADDR_W(AW), .PAGE_W(8), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .csb_i(csb), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .busy_o(busy), .cmd_stb_o(cmd_stb),
    .cmd_code_o(cmd_code), .req_o(req), .req_kind_o(req_kind),
    .req_page_o(req_page), .req_data_o(req_data), .grant_i(grant),
    .status_i(status_v)
  );

  int nchk = 0, nfail = 0;
  int ncmd = 0, nreq = 0, mcount = 0;
  logic [7:0] last_cmd, last_data;
  logic last_kind;
  int last_page;
  logic [7:0] mm [1 << AW];
  int pa[$];
  logic [7:0] pd[$];

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural reference, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy window", int'(busy), int'(mcount != 0));
      if (req && grant) mcount = WC;
      else if (mcount > 0) mcount--;
      if (cmd_stb) begin ncmd++; last_cmd = cmd_code; end
      if (req) begin
        nreq++; last_kind = req_kind; last_page = int'(req_page); last_data = req_data;
        if (grant && !req_kind)
          foreach (pa[k]) mm[pa[k]] = pd[k];
      end
    end
  end

  task automatic xbits(input logic [7:0] tx, input int nb,
                       output logic [7:0] rx, inout int oeh);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (!mode3) begin
        si = tx[i];
        repeat (H) @(negedge clk);
        rx[i] = so; if (so_oe) oeh++;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end else begin
        sck = 1'b0; si = tx[i];
        repeat (H) @(negedge clk);
        rx[i] = so; if (so_oe) oeh++;
        sck = 1'b1;
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, inout int oeh);
    xbits(tx, 8, rx, oeh);
  endtask

  task automatic sel();
    sck = mode3;
    repeat (H) @(negedge clk);
    csb = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    csb = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d; int o = 0;
    xbyte(op, d, o);
    xbyte(a[23:16], d, o); xbyte(a[15:8], d, o); xbyte(a[7:0], d, o);
  endtask

  task automatic page_wr(input logic [23:0] a, input int n, input int base);
    logic [7:0] d; int o = 0;
    pa.delete(); pd.delete();
    sel();
    send_hdr(8'h02, a);
    for (int k = 0; k < n; k++) begin
      xbyte(8'((base + k) & 255), d, o);
      pa.push_back(int'({a[AW-1:8], 8'((a[7:0] + k) & 255)}));
      pd.push_back(8'((base + k) & 255));
    end
    desel();
  endtask

  task automatic rd_chk(input logic [23:0] a, input int n, input string r);
    logic [7:0] d; int o = 0;
    sel();
    send_hdr(8'h03, a);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, d, o);
      chk(r, int'(d), int'(mm[(int'(a[AW-1:0]) + k) % (1 << AW)]));
    end
    chk("R2 oe during read data", o, 8 * n);
    desel();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int o, r0, c0;
    for (int i = 0; i < (1 << AW); i++) mm[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 so_oe after reset", int'(so_oe), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 req after reset", int'(req), 0);
    chk("R1 cmd_stb after reset", int'(cmd_stb), 0);
    rd_chk(24'h000010, 2, "R1 erased read");

    // R9 enable / disable strobes
    c0 = ncmd; o = 0;
    sel(); xbyte(8'h06, d, o); desel();
    chk("R9 enable strobe count", ncmd, c0 + 1);
    chk("R9 enable code", int'(last_cmd), 8'h06);
    sel(); xbyte(8'h04, d, o); desel();
    chk("R9 disable code", int'(last_cmd), 8'h04);
    chk("R9 no output on strobe cmds", o, 0);

    // R5 request, R6 granted commit
    r0 = nreq;
    page_wr(24'h000105, 3, 8'hA0);
    chk("R5 request count", nreq, r0 + 1);
    chk("R5 request kind", int'(last_kind), 0);
    chk("R5 request page", last_page, 1);

    // R8 status read while busy
    chk("R6 busy after grant", int'(busy), 1);
    o = 0; sel(); xbyte(8'h05, d, o);
    xbyte(8'h00, d, o); chk("R8 status byte 1", int'(d), 8'h8C);
    xbyte(8'h00, d, o); chk("R8 status byte 2", int'(d), 8'h8C);
    desel();
    chk("R8 oe during status", o, 16);

    // R7 refusals while busy
    c0 = ncmd; o = 0;
    sel(); xbyte(8'h03, d, o); xbyte(8'h00, d, o); desel();
    chk("R7 read refused no output", o, 0);
    sel(); xbyte(8'h06, d, o); desel();
    chk("R7 enable refused no strobe", ncmd, c0);
    wait_idle();
    rd_chk(24'h000104, 4, "R4 only received bytes written");

    // R6 no grant: nothing committed, no busy
    grant_en = 1'b0; r0 = nreq;
    page_wr(24'h000200, 1, 8'h55);
    chk("R6 ungranted request seen", nreq, r0 + 1);
    chk("R6 no busy without grant", int'(busy), 0);
    grant_en = 1'b1;
    rd_chk(24'h000200, 1, "R6 ungranted write absent");

    // R5 partial byte raises no request
    r0 = nreq; o = 0;
    sel(); send_hdr(8'h02, 24'h000201);
    xbyte(8'h12, d, o); xbits(8'h34, 4, d, o);
    desel();
    chk("R5 no request on partial byte", nreq, r0);

    // R4 in-page wrap over 258 bytes
    page_wr(24'h0000FE, 258, 0);
    wait_idle();
    rd_chk(24'h0000FE, 4, "R4 page wrap and overwrite");

    // R12 unknown command locks
    c0 = ncmd; r0 = nreq; o = 0;
    sel(); xbyte(8'h77, d, o); xbyte(8'h06, d, o); xbyte(8'h05, d, o);
    xbyte(8'h00, d, o); desel();
    chk("R12 lock no output", o, 0);
    chk("R12 lock no strobe", ncmd, c0);
    chk("R12 lock no request", nreq, r0);
    o = 0; sel(); xbyte(8'h05, d, o); xbyte(8'h00, d, o); desel();
    chk("R12 unlocked by new select", int'(d), 8'h8C);

    // R11 identification
    o = 0; sel(); xbyte(8'hAB, d, o);
    xbyte(8'h00, d, o); xbyte(8'h00, d, o); xbyte(8'h00, d, o);
    chk("R11 no output during padding", o, 0);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, d, o);
      chk("R11 identification byte", int'(d), 8'h11);
    end
    desel();

    // R10 status write request, then R7 refusal of identification
    r0 = nreq; o = 0;
    sel(); xbyte(8'h01, d, o); xbyte(8'h3C, d, o); desel();
    chk("R10 request count", nreq, r0 + 1);
    chk("R10 request kind", int'(last_kind), 1);
    chk("R10 request data", int'(last_data), 8'h3C);
    chk("R10 busy after grant", int'(busy), 1);
    o = 0; sel(); xbyte(8'hAB, d, o);
    for (int k = 0; k < 4; k++) xbyte(8'h00, d, o);
    desel();
    chk("R7 identification refused", o, 0);
    wait_idle();

    // R2 idle-high clock, R3 wrap across array end, high bits ignored
    mode3 = 1'b1;
    page_wr(24'h0003FE, 2, 8'h5A);
    chk("R2 idle-high write request page", last_page, 3);
    wait_idle();
    rd_chk(24'hFC03FE, 4, "R3 array wrap high bits ignored");
    mode3 = 1'b0;
    rd_chk(24'h0000FF, 2, "R3 read crosses page edge");

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule